// File: doc/BRIEF.md
# Two-Level Address Translation Buffer

This block translates virtual page numbers to page frame numbers through two levels of cached page table entries. The first level is a tiny fully associative buffer with one entry kept for instruction-stream references and a small set of data entries. A lookup that hits there returns its frame number combinationally, in the cycle of the request. A lookup that misses stalls the requester. The block probes a larger second-level buffer, refills the first level on a hit, and presents the translation two cycles after the request. When both levels miss, it raises a miss flag so that a page walker or microcode can take over.

The second level is split into a system half and a process half, chosen by the top bit of the virtual page number. Each half is organised as groups of four consecutive entries that share one address tag. The tags and the per-entry frame storage are held apart, and every entry carries its own valid bit. Software or a walker loads second-level entries through a fill port. A single invalidate input clears both levels in one cycle.

Top module: `xlat_two_level`

## Requirements
- R1: After reset, `req_ready_o` is 1 and both response outputs are 0, and the first lookup of any page reports a miss (`resp_miss_o`) two cycles after the request.
- R2: A lookup that hits the first level drives `resp_valid_o`=1 and the stored frame number in the same cycle, and `req_ready_o` stays 1.
- R3: An instruction lookup (`req_istream_i`=1) compares only against the instruction entry, and a data lookup compares only against the data entries.
- R4: A first-level miss drops `req_ready_o` for two cycles. In the second cycle after the request it drives `resp_valid_o`=1 with the second-level frame number, and the translation then hits the first level.
- R5: A miss in both levels drives `resp_miss_o`=1 and `resp_valid_o`=0 in the second cycle after the request, and leaves every first-level entry unchanged.
- R6: Virtual page number layout: bit VPN_W-1 picks the system (1) or process (0) half, bits [1:0] pick the slot in a group, bits [7:2] index one of 64 tags, and bits [VPN_W-2:8] form the compared tag. Pages that differ only in bit VPN_W-1 are distinct entries.
- R7: A fill whose tag differs from the tag stored at its index installs the new tag and invalidates the other three slots of the group. A fill with a matching tag leaves the other slots valid.
- R8: A second-level tag match on a slot whose valid bit is clear counts as a miss.
- R9: Data refills go round-robin over the data entries, starting at entry 0. The fifth distinct data refill evicts the first one.
- R10: Every instruction-side refill overwrites the single instruction entry, so the previous instruction translation no longer hits.
- R11: `inv_all_i` clears every valid bit in both levels in one cycle. It overrides a fill in the same cycle, and it abandons a pending miss without any response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_all_i | input | 1 | Invalidate both levels |
| req_valid_i | input | 1 | Lookup request |
| req_vpn_i | input | VPN_W | Virtual page number of the lookup |
| req_istream_i | input | 1 | 1 = instruction-stream lookup, 0 = data |
| req_ready_o | output | 1 | Block can accept a lookup |
| resp_valid_o | output | 1 | Translation valid on resp_pfn_o |
| resp_miss_o | output | 1 | Lookup missed in both levels |
| resp_pfn_o | output | PFN_W | Translated page frame number |
| fill_en_i | input | 1 | Write one second-level entry |
| fill_vpn_i | input | VPN_W | Virtual page number of the fill |
| fill_pfn_i | input | PFN_W | Frame number of the fill |

## Verification
The hardest cases to reach are those where the outcome depends on state hidden behind the first level. Examples are a tag that still matches while its slot has become invalid, and a group whose siblings a later fill has evicted. A data lookup would hit the first level and mask both. The stimulus therefore probes the second level through the instruction side, whose single entry is easy to displace, so each such lookup is forced down the slow path. The round-robin order is exposed by filling all data entries and one more. The stimulus then checks which translations still answer in the request cycle before it touches the evicted one.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int unsigned DEF_VPN_W = 16;
  localparam int unsigned DEF_PFN_W = 12;
  localparam int unsigned DEF_D_ENT = 4;
  localparam int unsigned DEF_GRP_W = 2;
  localparam int unsigned DEF_IDX_W = 6;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_PROBE = 2'd1,
    XS_DONE  = 2'd2
  } xl_state_e;

endpackage

// File: rtl/xlat_mini.sv
module xlat_mini #(
  parameter int unsigned VPN_W = xlat_pkg::DEF_VPN_W,
  parameter int unsigned PFN_W = xlat_pkg::DEF_PFN_W,
  parameter int unsigned D_ENT = xlat_pkg::DEF_D_ENT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic             lk_ist_i,
  output logic             hit_o,
  output logic [PFN_W-1:0] pfn_o,
  input  logic             ref_en_i,
  input  logic             ref_ist_i,
  input  logic [VPN_W-1:0] ref_vpn_i,
  input  logic [PFN_W-1:0] ref_pfn_i
);

  localparam int unsigned PTR_W = (D_ENT > 1) ? $clog2(D_ENT) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(D_ENT - 1);

  logic [VPN_W-1:0] d_vpn_q [D_ENT];
  logic [PFN_W-1:0] d_pfn_q [D_ENT];
  logic [D_ENT-1:0] d_v_q, d_v_d, d_we, d_match;
  logic [VPN_W-1:0] i_vpn_q;
  logic [PFN_W-1:0] i_pfn_q;
  logic             i_v_q, i_v_d, i_we, i_match;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [PFN_W-1:0] d_sel;

  // lookup: one comparator per data entry
  for (genvar g = 0; g < D_ENT; g++) begin : g_cmp
    assign d_match[g] = d_v_q[g] && (d_vpn_q[g] == lk_vpn_i);
  end
  assign i_match = i_v_q && (i_vpn_q == lk_vpn_i);

  always_comb begin
    d_sel = '0;
    for (int g = 0; g < D_ENT; g++) begin
      if (d_match[g]) d_sel = d_sel | d_pfn_q[g];
    end
    hit_o = lk_ist_i ? i_match : (|d_match);
    pfn_o = lk_ist_i ? i_pfn_q : d_sel;
  end

  // next state
  always_comb begin
    d_v_d = d_v_q;
    i_v_d = i_v_q;
    ptr_d = ptr_q;
    d_we  = '0;
    i_we  = 1'b0;
    if (inv_i) begin
      d_v_d = '0;
      i_v_d = 1'b0;
    end else if (ref_en_i) begin
      if (ref_ist_i) begin
        i_we  = 1'b1;
        i_v_d = 1'b1;
      end else begin
        d_we[ptr_q]  = 1'b1;
        d_v_d[ptr_q] = 1'b1;
        ptr_d = (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_v_q <= '0;
      i_v_q <= 1'b0;
      ptr_q <= '0;
    end else begin
      d_v_q <= d_v_d;
      i_v_q <= i_v_d;
      ptr_q <= ptr_d;
    end
  end

  // entry storage, write-enabled, not reset
  for (genvar g = 0; g < D_ENT; g++) begin : g_store
    always_ff @(posedge clk) begin
      if (d_we[g]) begin
        d_vpn_q[g] <= ref_vpn_i;
        d_pfn_q[g] <= ref_pfn_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (i_we) begin
      i_vpn_q <= ref_vpn_i;
      i_pfn_q <= ref_pfn_i;
    end
  end

  // a page is never held twice among the data entries
  assert_single_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(d_match));

  assert_mini_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
    inv_i |=> (d_v_q == '0) && !i_v_q);

endmodule

// File: rtl/xlat_backup.sv
module xlat_backup #(
  parameter int unsigned VPN_W = xlat_pkg::DEF_VPN_W,
  parameter int unsigned PFN_W = xlat_pkg::DEF_PFN_W,
  parameter int unsigned GRP_W = xlat_pkg::DEF_GRP_W,
  parameter int unsigned IDX_W = xlat_pkg::DEF_IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_i,
  input  logic [VPN_W-1:0] probe_vpn_i,
  output logic             probe_hit_o,
  output logic [PFN_W-1:0] probe_pfn_o,
  input  logic             fill_en_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i
);

  localparam int unsigned TAG_W = VPN_W - 1 - GRP_W - IDX_W;
  localparam int unsigned TI_W  = IDX_W + 1;
  localparam int unsigned EI_W  = TI_W + GRP_W;
  localparam int unsigned NTAG  = 1 << TI_W;
  localparam int unsigned NENT  = 1 << EI_W;
  localparam int unsigned GRP   = 1 << GRP_W;

  logic [TAG_W-1:0] tag_q [NTAG];
  logic [PFN_W-1:0] pfn_q [NENT];
  logic [NTAG-1:0]  tag_v_q, tag_v_d;
  logic [NENT-1:0]  ent_v_q, ent_v_d;

  logic [TI_W-1:0]  p_ti, f_ti;
  logic [EI_W-1:0]  p_ei, f_ei;
  logic [TAG_W-1:0] p_tag, f_tag;
  logic [GRP_W-1:0] f_grp;
  logic             f_same, tag_we, pfn_we;

  // field split: space bit, tag, tag index, slot in group
  assign p_ti  = {probe_vpn_i[VPN_W-1], probe_vpn_i[GRP_W +: IDX_W]};
  assign p_ei  = {p_ti, probe_vpn_i[GRP_W-1:0]};
  assign p_tag = probe_vpn_i[VPN_W-2 -: TAG_W];
  assign f_ti  = {fill_vpn_i[VPN_W-1], fill_vpn_i[GRP_W +: IDX_W]};
  assign f_grp = fill_vpn_i[GRP_W-1:0];
  assign f_ei  = {f_ti, f_grp};
  assign f_tag = fill_vpn_i[VPN_W-2 -: TAG_W];

  assign probe_hit_o = tag_v_q[p_ti] && (tag_q[p_ti] == p_tag) && ent_v_q[p_ei];
  assign probe_pfn_o = pfn_q[p_ei];

  assign f_same = tag_v_q[f_ti] && (tag_q[f_ti] == f_tag);
  assign tag_we = fill_en_i && !inv_i && !f_same;
  assign pfn_we = fill_en_i && !inv_i;

  // next state of the valid bits
  always_comb begin
    tag_v_d = tag_v_q;
    ent_v_d = ent_v_q;
    if (inv_i) begin
      tag_v_d = '0;
      ent_v_d = '0;
    end else if (fill_en_i) begin
      tag_v_d[f_ti] = 1'b1;
      for (int g = 0; g < GRP; g++) begin
        ent_v_d[{f_ti, GRP_W'(g)}] = (GRP_W'(g) == f_grp) ||
                                     (f_same && ent_v_q[{f_ti, GRP_W'(g)}]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_v_q <= '0;
      ent_v_q <= '0;
    end else begin
      tag_v_q <= tag_v_d;
      ent_v_q <= ent_v_d;
    end
  end

  // tag and frame storage, write-enabled, not reset
  always_ff @(posedge clk) begin
    if (tag_we) tag_q[f_ti] <= f_tag;
    if (pfn_we) pfn_q[f_ei] <= fill_pfn_i;
  end

  assert_fill_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en_i && !inv_i) |=> ent_v_q[$past(f_ei)]);

  assert_backup_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
    inv_i |=> (ent_v_q == '0) && (tag_v_q == '0));

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int unsigned VPN_W = DEF_VPN_W,
  parameter int unsigned PFN_W = DEF_PFN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_i,
  input  logic             req_valid_i,
  input  logic [VPN_W-1:0] req_vpn_i,
  input  logic             req_ist_i,
  output logic             req_ready_o,
  output logic             resp_valid_o,
  output logic             resp_miss_o,
  output logic [PFN_W-1:0] resp_pfn_o,
  input  logic             mini_hit_i,
  input  logic [PFN_W-1:0] mini_pfn_i,
  input  logic             bk_hit_i,
  input  logic [PFN_W-1:0] bk_pfn_i,
  output logic [VPN_W-1:0] probe_vpn_o,
  output logic             ref_en_o,
  output logic             ref_ist_o,
  output logic [VPN_W-1:0] ref_vpn_o,
  output logic [PFN_W-1:0] ref_pfn_o
);

  xl_state_e        st_q, st_d;
  logic [VPN_W-1:0] vpn_q;
  logic             ist_q, hit_q, cap_req, cap_res;
  logic [PFN_W-1:0] pfn_q;

  // next state
  always_comb begin
    st_d    = st_q;
    cap_req = 1'b0;
    cap_res = 1'b0;
    unique case (st_q)
      XS_IDLE: begin
        if (req_valid_i && !mini_hit_i && !inv_i) begin
          cap_req = 1'b1;
          st_d    = XS_PROBE;
        end
      end
      XS_PROBE: begin
        cap_res = 1'b1;
        st_d    = inv_i ? XS_IDLE : XS_DONE;
      end
      default: st_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= XS_IDLE;
    else        st_q <= st_d;
  end

  // captured request and probe result, enable-gated
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q <= '0;
      ist_q <= 1'b0;
      hit_q <= 1'b0;
      pfn_q <= '0;
    end else begin
      if (cap_req) begin
        vpn_q <= req_vpn_i;
        ist_q <= req_ist_i;
      end
      if (cap_res) begin
        hit_q <= bk_hit_i;
        pfn_q <= bk_pfn_i;
      end
    end
  end

  always_comb begin
    req_ready_o  = (st_q == XS_IDLE);
    resp_valid_o = (st_q == XS_IDLE) ? (req_valid_i && mini_hit_i)
                                     : ((st_q == XS_DONE) && hit_q);
    resp_miss_o  = (st_q == XS_DONE) && !hit_q;
    resp_pfn_o   = (st_q == XS_IDLE) ? mini_pfn_i : pfn_q;
  end

  assign probe_vpn_o = vpn_q;
  assign ref_en_o    = (st_q == XS_DONE) && hit_q && !inv_i;
  assign ref_ist_o   = ist_q;
  assign ref_vpn_o   = vpn_q;
  assign ref_pfn_o   = pfn_q;

  assert_resp_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_valid_o && resp_miss_o));

  assert_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o && !mini_hit_i && !inv_i) |=> !req_ready_o);

  assert_answer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready_o && !resp_valid_o && !resp_miss_o && !inv_i) |=>
      (resp_valid_o || resp_miss_o));

endmodule

// File: rtl/xlat_two_level.sv
module xlat_two_level
  import xlat_pkg::*;
#(
  parameter int unsigned VPN_W = DEF_VPN_W,
  parameter int unsigned PFN_W = DEF_PFN_W,
  parameter int unsigned D_ENT = DEF_D_ENT,
  parameter int unsigned GRP_W = DEF_GRP_W,
  parameter int unsigned IDX_W = DEF_IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_all_i,
  input  logic             req_valid_i,
  input  logic [VPN_W-1:0] req_vpn_i,
  input  logic             req_istream_i,
  output logic             req_ready_o,
  output logic             resp_valid_o,
  output logic             resp_miss_o,
  output logic [PFN_W-1:0] resp_pfn_o,
  input  logic             fill_en_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i
);

  logic [1:0]       rst_sync_q;
  logic             rst_n_s;
  logic             mini_hit, bk_hit, ref_en, ref_ist;
  logic [PFN_W-1:0] mini_pfn, bk_pfn, ref_pfn;
  logic [VPN_W-1:0] probe_vpn, ref_vpn;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  xlat_mini #(.VPN_W(VPN_W), .PFN_W(PFN_W), .D_ENT(D_ENT)) u_mini (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .inv_i     (inv_all_i),
    .lk_vpn_i  (req_vpn_i),
    .lk_ist_i  (req_istream_i),
    .hit_o     (mini_hit),
    .pfn_o     (mini_pfn),
    .ref_en_i  (ref_en),
    .ref_ist_i (ref_ist),
    .ref_vpn_i (ref_vpn),
    .ref_pfn_i (ref_pfn)
  );

  xlat_backup #(.VPN_W(VPN_W), .PFN_W(PFN_W), .GRP_W(GRP_W), .IDX_W(IDX_W)) u_backup (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .inv_i       (inv_all_i),
    .probe_vpn_i (probe_vpn),
    .probe_hit_o (bk_hit),
    .probe_pfn_o (bk_pfn),
    .fill_en_i   (fill_en_i),
    .fill_vpn_i  (fill_vpn_i),
    .fill_pfn_i  (fill_pfn_i)
  );

  xlat_ctrl #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .inv_i        (inv_all_i),
    .req_valid_i  (req_valid_i),
    .req_vpn_i    (req_vpn_i),
    .req_ist_i    (req_istream_i),
    .req_ready_o  (req_ready_o),
    .resp_valid_o (resp_valid_o),
    .resp_miss_o  (resp_miss_o),
    .resp_pfn_o   (resp_pfn_o),
    .mini_hit_i   (mini_hit),
    .mini_pfn_i   (mini_pfn),
    .bk_hit_i     (bk_hit),
    .bk_pfn_i     (bk_pfn),
    .probe_vpn_o  (probe_vpn),
    .ref_en_o     (ref_en),
    .ref_ist_o    (ref_ist),
    .ref_vpn_o    (ref_vpn),
    .ref_pfn_o    (ref_pfn)
  );

endmodule

// File: tb/xlat_two_level_tb.sv
`timescale 1ns/1ps
module xlat_two_level_tb_top;

  localparam int VPN_W = 16;
  localparam int PFN_W = 12;
  localparam logic [1:0] K_FAST = 2'd0;  // answered in the request cycle
  localparam logic [1:0] K_SLOW = 2'd1;  // answered two cycles later
  localparam logic [1:0] K_MISS = 2'd2;  // miss flag two cycles later

  function automatic logic [VPN_W-1:0] mkvpn(input int s, input int t, input int i, input int g);
    return {s[0], t[6:0], i[5:0], g[1:0]};
  endfunction

  typedef struct packed {
    logic             ist;
    logic [VPN_W-1:0] vpn;
    logic [1:0]       kind;
    logic [PFN_W-1:0] pfn;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, mkvpn(0,5,3,0),  K_SLOW, 12'd100}, // R4 first-level miss, backup hit
    '{1'b0, mkvpn(0,5,3,0),  K_FAST, 12'd100}, // R2 now in first level
    '{1'b0, mkvpn(1,5,3,0),  K_SLOW, 12'd200}, // R6 system half distinct
    '{1'b0, mkvpn(0,5,3,1),  K_SLOW, 12'd101}, // R6 neighbouring slot
    '{1'b1, mkvpn(0,5,3,0),  K_SLOW, 12'd100}, // R3 instr side ignores data entries
    '{1'b1, mkvpn(0,5,3,0),  K_FAST, 12'd100}, // R3 instr entry hit
    '{1'b0, mkvpn(0,5,3,2),  K_MISS, 12'd0},   // R8 tag match, slot invalid
    '{1'b0, mkvpn(0,6,3,0),  K_MISS, 12'd0},   // R5 tag mismatch
    '{1'b0, mkvpn(0,5,3,0),  K_FAST, 12'd100}, // R5 first level untouched by miss
    '{1'b1, mkvpn(0,9,10,2), K_SLOW, 12'd300}, // R10 instr refill
    '{1'b1, mkvpn(0,5,3,0),  K_SLOW, 12'd100}, // R10 old instr entry overwritten
    '{1'b0, mkvpn(0,9,10,2), K_SLOW, 12'd300}  // R9 fills data entry 3
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             inv_all_i, req_valid_i, req_istream_i, fill_en_i;
  logic [VPN_W-1:0] req_vpn_i, fill_vpn_i;
  logic [PFN_W-1:0] fill_pfn_i;
  logic             req_ready_o, resp_valid_o, resp_miss_o;
  logic [PFN_W-1:0] resp_pfn_o;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  xlat_two_level dut_i (
    .clk(clk), .rst_n(rst_n), .inv_all_i(inv_all_i),
    .req_valid_i(req_valid_i), .req_vpn_i(req_vpn_i), .req_istream_i(req_istream_i),
    .req_ready_o(req_ready_o), .resp_valid_o(resp_valid_o), .resp_miss_o(resp_miss_o),
    .resp_pfn_o(resp_pfn_o), .fill_en_i(fill_en_i), .fill_vpn_i(fill_vpn_i),
    .fill_pfn_i(fill_pfn_i)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic [PFN_W-1:0] p);
    @(negedge clk);
    fill_en_i = 1'b1; fill_vpn_i = v; fill_pfn_i = p;
    @(negedge clk);
    fill_en_i = 1'b0;
  endtask

  task automatic pulse_inv();
    @(negedge clk);
    inv_all_i = 1'b1;
    @(negedge clk);
    inv_all_i = 1'b0;
  endtask

  // kind: 0 fast, 1 slow, 2 miss, 3 protocol error
  task automatic lookup(input logic ist, input logic [VPN_W-1:0] v,
                        input logic [1:0] ek, input logic [PFN_W-1:0] ep,
                        input string req);
    int got;
    logic [PFN_W-1:0] gp;
    gp = '0;
    @(negedge clk);
    req_valid_i = 1'b1; req_vpn_i = v; req_istream_i = ist;
    #1;
    if (resp_valid_o && req_ready_o) begin
      got = 0; gp = resp_pfn_o;
      @(negedge clk);
      req_valid_i = 1'b0;
    end else begin
      got = 3;
      @(negedge clk);
      req_valid_i = 1'b0;
      #1;
      if (!req_ready_o && !resp_valid_o && !resp_miss_o) begin
        @(negedge clk);
        #1;
        if (!req_ready_o && resp_valid_o && !resp_miss_o) begin got = 1; gp = resp_pfn_o; end
        else if (!req_ready_o && resp_miss_o && !resp_valid_o) got = 2;
      end
    end
    check(got == int'(ek), {req, " response kind"}, got, int'(ek));
    if (ek != K_MISS)
      check(gp == ep, {req, " frame number"}, int'(gp), int'(ep));
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; inv_all_i = 1'b0; req_valid_i = 1'b0; req_istream_i = 1'b0;
    fill_en_i = 1'b0; req_vpn_i = '0; fill_vpn_i = '0; fill_pfn_i = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(req_ready_o == 1'b1, "R1 ready in reset", int'(req_ready_o), 1);
    check(!resp_valid_o && !resp_miss_o, "R1 quiet outputs in reset",
          int'({resp_valid_o, resp_miss_o}), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(req_ready_o == 1'b1, "R1 ready after reset", int'(req_ready_o), 1);
    lookup(1'b0, mkvpn(0,5,3,0), K_MISS, 12'd0, "R1 empty after reset");

    fill(mkvpn(0,5,3,0), 12'd100);
    fill(mkvpn(0,5,3,1), 12'd101);
    fill(mkvpn(1,5,3,0), 12'd200);
    fill(mkvpn(0,9,10,2), 12'd300);

    for (int k = 0; k < NV; k++)
      lookup(VECS[k].ist, VECS[k].vpn, VECS[k].kind, VECS[k].pfn,
             $sformatf("vector %0d", k));

    // R9: fifth data refill evicts entry 0 (page 0,5,3,0)
    fill(mkvpn(0,9,10,3), 12'd301);
    lookup(1'b0, mkvpn(0,9,10,3), K_SLOW, 12'd301, "R9 fifth refill");
    lookup(1'b0, mkvpn(1,5,3,0),  K_FAST, 12'd200, "R9 entry 1 kept");
    lookup(1'b0, mkvpn(0,5,3,1),  K_FAST, 12'd101, "R9 entry 2 kept");
    lookup(1'b0, mkvpn(0,9,10,2), K_FAST, 12'd300, "R9 entry 3 kept");
    lookup(1'b0, mkvpn(0,5,3,0),  K_SLOW, 12'd100, "R9 entry 0 evicted");

    // R7: same-tag fill kept slot 2 valid; different tag evicts the group
    lookup(1'b1, mkvpn(0,9,10,2), K_SLOW, 12'd300, "R7 same tag keeps sibling");
    fill(mkvpn(0,12,3,2), 12'd400);
    lookup(1'b1, mkvpn(0,5,3,1),  K_MISS, 12'd0,   "R7 new tag evicts sibling");
    lookup(1'b1, mkvpn(0,12,3,2), K_SLOW, 12'd400, "R7 new tag installed");
    lookup(1'b1, mkvpn(1,5,3,0),  K_SLOW, 12'd200, "R6 other half untouched");

    // R11: invalidate clears both levels
    pulse_inv();
    lookup(1'b0, mkvpn(1,5,3,0),  K_MISS, 12'd0, "R11 data level cleared");
    lookup(1'b1, mkvpn(1,5,3,0),  K_MISS, 12'd0, "R11 instr level cleared");

    // R11: invalidate wins over a fill in the same cycle
    @(negedge clk);
    inv_all_i = 1'b1; fill_en_i = 1'b1; fill_vpn_i = mkvpn(0,20,40,1); fill_pfn_i = 12'd77;
    @(negedge clk);
    inv_all_i = 1'b0; fill_en_i = 1'b0;
    lookup(1'b1, mkvpn(0,20,40,1), K_MISS, 12'd0, "R11 fill overridden");

    // R11: invalidate during a pending miss abandons it
    fill(mkvpn(0,20,40,1), 12'd77);
    @(negedge clk);
    req_valid_i = 1'b1; req_vpn_i = mkvpn(0,20,40,1); req_istream_i = 1'b0;
    @(negedge clk);
    req_valid_i = 1'b0; inv_all_i = 1'b1;
    @(negedge clk);
    inv_all_i = 1'b0;
    #1;
    check(!resp_valid_o && !resp_miss_o && req_ready_o, "R11 pending miss abandoned",
          int'({req_ready_o, resp_valid_o, resp_miss_o}), 4);
    lookup(1'b0, mkvpn(0,20,40,1), K_MISS, 12'd0, "R11 abandoned page not refilled");

    finished = 1'b1;
    summary();
  end

endmodule